// File: doc/BRIEF.md
# Paged Frame-Buffer Pixel Scanner

This block walks a byte-organised display memory and turns it into a raster stream of one-bit pixels. The memory holds 8 pages × 132 columns of bytes. Each byte carries 8 vertically stacked pixels, and bit 0 is the topmost one. The scanner emits a visible window of 16 lines × 96 pixels, row by row and left to right. Every pixel leaves on a valid/ready handshake. Side flags mark the first pixel of a frame and the last pixel of each line.

A frame runs only when a redraw is pending. The `invalidate_i` pulse raises the pending flag. The flag drops when the final pixel of a frame is accepted downstream. A vertical scroll offset, an invert option and a force-all-lit option are sampled when a frame begins. The memory is synchronous with one cycle of read latency. The scanner therefore drives the read address one cycle before the matching byte is turned into a pixel. It keeps driving that address while the output is stalled.

Top module: `oled_scanout`

## Requirements
- R1: While reset is held and right after it, `pix_valid_o` and `redraw_pending_o` are 0.
- R2: A frame is exactly 1536 accepted pixels: 16 lines of 96. `frame_start_o` is 1 only on the first pixel of the frame. `line_end_o` is 1 only on the 96th pixel of each line.
- R3: Output row y uses memory line L = (y + scroll) mod 64. The byte comes from page L/8, and the pixel is bit (L mod 8) of that byte, with bit 0 at the top.
- R4: Visible pixel x reads memory column 36 + x. The byte address is page × 132 + column, and it always stays inside that visible column window.
- R5: With invert set and force-lit clear, the pixel is the complement of the memory bit. With both clear, the pixel equals the memory bit.
- R6: With force-lit set, every pixel is 1, whatever the memory and invert hold.
- R7: With no redraw pending, no pixel is produced. A one-cycle `invalidate_i` pulse sets the pending flag on the next cycle and starts a frame.
- R8: The pending flag clears when the last pixel of a frame is accepted. An `invalidate_i` in that same cycle wins and keeps the flag set, so another frame follows. An `invalidate_i` earlier in a frame has no lasting effect.
- R9: While `pix_valid_o` is 1 and `pix_ready_i` is 0, the pixel and both flags hold steady on the next cycle.
- R10: The scroll, invert and force-lit inputs are captured when a frame starts. Changing them during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| invalidate_i | input | 1 | Redraw request pulse |
| start_line_i | input | 6 | Vertical scroll offset in lines |
| inverse_i | input | 1 | Invert pixel polarity |
| all_on_i | input | 1 | Force every pixel lit |
| ram_addr_o | output | 11 | Display memory read address |
| ram_rdata_i | input | 8 | Read byte, valid one cycle after the address |
| pix_ready_i | input | 1 | Downstream accepts the pixel |
| pix_valid_o | output | 1 | Pixel is valid |
| pix_o | output | 1 | Pixel value |
| frame_start_o | output | 1 | First pixel of a frame |
| line_end_o | output | 1 | Last pixel of a line |
| redraw_pending_o | output | 1 | A redraw is pending |

## Verification
Two events can land in the same cycle: a fresh redraw request and the acceptance of a frame's final pixel, which clears the pending flag. The bench watches for the handshake on pixel 1535 and pulses `invalidate_i` in that very cycle. It then expects the flag to stay high and a second full frame to follow without any further request. In a separate run, a request issued mid-frame must leave the flag clear and the output quiet once the frame ends. Random back-pressure is applied throughout, so that final acceptance falls on varied cycles.

// File: rtl/oled_scan_pkg.sv
package oled_scan_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FETCH = 2'd1,
        PH_DRAIN = 2'd2
    } scan_phase_e;

    localparam int BYTE_W      = 8;
    localparam int BIT_W       = 3;
    localparam int DEF_PAGES   = 8;
    localparam int DEF_COLS    = 132;
    localparam int DEF_VIS_W   = 96;
    localparam int DEF_VIS_H   = 16;
    localparam int DEF_COL_OFS = 36;

endpackage

// File: rtl/oled_scan_seq.sv
// Frame sequencer: redraw flag, frame phase, fetch coordinates, captured config.
module oled_scan_seq
    import oled_scan_pkg::*;
#(
    parameter int VIS_W  = DEF_VIS_W,
    parameter int VIS_H  = DEF_VIS_H,
    parameter int LINE_W = 6,
    parameter int X_W    = $clog2(VIS_W),
    parameter int Y_W    = $clog2(VIS_H)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              invalidate_i,
    input  logic [LINE_W-1:0] start_line_i,
    input  logic              inverse_i,
    input  logic              all_on_i,
    input  logic              take_i,
    input  logic              frame_done_i,
    output logic              fvalid_o,
    output logic [BIT_W-1:0]  bit_o,
    output logic              inv_o,
    output logic              allon_o,
    output logic              first_o,
    output logic              lend_o,
    output logic              last_o,
    output logic [X_W-1:0]    nx_o,
    output logic [Y_W-1:0]    ny_o,
    output logic [LINE_W-1:0] nsl_o,
    output logic              pending_o
);

    typedef struct packed {
        scan_phase_e       phase;
        logic              pending;
        logic              fvalid;
        logic [X_W-1:0]    x;
        logic [Y_W-1:0]    y;
        logic [LINE_W-1:0] sl;
        logic              inv;
        logic              allon;
    } seq_t;

    seq_t q, d;
    logic x_last, y_last, adv;

    assign x_last = (q.x == X_W'(VIS_W - 1));
    assign y_last = (q.y == Y_W'(VIS_H - 1));
    assign adv    = q.fvalid && take_i;

    always_comb begin
        d = q;
        unique case (q.phase)
            PH_IDLE: begin
                if (q.pending) begin
                    d.phase  = PH_FETCH;
                    d.fvalid = 1'b1;
                    d.x      = '0;
                    d.y      = '0;
                    d.sl     = start_line_i;
                    d.inv    = inverse_i;
                    d.allon  = all_on_i;
                end
            end
            PH_FETCH: begin
                if (adv) begin
                    if (x_last) begin
                        d.x = '0;
                        if (y_last) begin
                            d.fvalid = 1'b0;
                            d.phase  = PH_DRAIN;
                        end else begin
                            d.y = q.y + Y_W'(1);
                        end
                    end else begin
                        d.x = q.x + X_W'(1);
                    end
                end
            end
            PH_DRAIN: begin
                if (frame_done_i) d.phase = PH_IDLE;
            end
            default: d.phase = PH_IDLE;
        endcase
        if (frame_done_i) d.pending = 1'b0;
        if (invalidate_i) d.pending = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fvalid_o  = q.fvalid;
    assign bit_o     = BIT_W'(q.y) + q.sl[BIT_W-1:0];
    assign inv_o     = q.inv;
    assign allon_o   = q.allon;
    assign first_o   = (q.x == '0) && (q.y == '0);
    assign lend_o    = x_last;
    assign last_o    = x_last && y_last;
    assign nx_o      = d.x;
    assign ny_o      = d.y;
    assign nsl_o     = d.sl;
    assign pending_o = q.pending;

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_IDLE && !q.pending) |=> (q.phase == PH_IDLE && !q.fvalid));

    // R8
    pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done_i && !invalidate_i) |=> !q.pending);

    // R8
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        invalidate_i |=> q.pending);

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase != PH_IDLE) |=> ($stable(q.sl) && $stable(q.inv) && $stable(q.allon)));

endmodule

// File: rtl/oled_scan_addr.sv
// Maps a window coordinate plus scroll to a byte address in the paged memory.
module oled_scan_addr
    import oled_scan_pkg::*;
#(
    parameter int COLS    = DEF_COLS,
    parameter int COL_OFS = DEF_COL_OFS,
    parameter int LINE_W  = 6,
    parameter int ADDR_W  = 11,
    parameter int X_W     = 7,
    parameter int Y_W     = 4
) (
    input  logic [X_W-1:0]    x_i,
    input  logic [Y_W-1:0]    y_i,
    input  logic [LINE_W-1:0] sl_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int PAGE_W = LINE_W - BIT_W;

    logic [LINE_W-1:0] line;
    logic [PAGE_W-1:0] page;

    always_comb begin
        line   = LINE_W'(y_i) + sl_i;
        page   = line[LINE_W-1:BIT_W];
        addr_o = ADDR_W'(page) * ADDR_W'(COLS) + ADDR_W'(COL_OFS) + ADDR_W'(x_i);
    end

endmodule

// File: rtl/oled_scan_out.sv
// Output register: forms the pixel from the returned byte and holds it under back-pressure.
module oled_scan_out
    import oled_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fvalid_i,
    input  logic [BYTE_W-1:0] rdata_i,
    input  logic [BIT_W-1:0]  bit_i,
    input  logic              inv_i,
    input  logic              allon_i,
    input  logic              first_i,
    input  logic              lend_i,
    input  logic              last_i,
    input  logic              pix_ready_i,
    output logic              take_o,
    output logic              pix_valid_o,
    output logic              pix_o,
    output logic              frame_start_o,
    output logic              line_end_o,
    output logic              frame_done_o
);

    typedef struct packed {
        logic valid;
        logic pix;
        logic fs;
        logic le;
        logic last;
    } out_t;

    out_t q, d;

    assign take_o = !q.valid || pix_ready_i;

    always_comb begin
        d = q;
        if (q.valid && pix_ready_i) d.valid = 1'b0;
        if (fvalid_i && take_o) begin
            d.valid = 1'b1;
            d.pix   = allon_i ? 1'b1 : (rdata_i[bit_i] ^ inv_i);
            d.fs    = first_i;
            d.le    = lend_i;
            d.last  = last_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pix_valid_o   = q.valid;
    assign pix_o         = q.pix;
    assign frame_start_o = q.valid && q.fs;
    assign line_end_o    = q.valid && q.le;
    assign frame_done_o  = q.valid && pix_ready_i && q.last;

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.valid && !pix_ready_i) |=>
            (q.valid && $stable(q.pix) && $stable(q.fs) && $stable(q.le)));

    // R2
    mark_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |-> !line_end_o);

    // R6
    all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fvalid_i && take_o && allon_i) |=> (pix_valid_o && pix_o));

endmodule

// File: rtl/oled_scanout.sv
module oled_scanout
    import oled_scan_pkg::*;
#(
    parameter int PAGES    = DEF_PAGES,
    parameter int COLS     = DEF_COLS,
    parameter int VIS_W    = DEF_VIS_W,
    parameter int VIS_H    = DEF_VIS_H,
    parameter int COL_OFS  = DEF_COL_OFS,
    localparam int LINE_W  = $clog2(PAGES * BYTE_W),
    localparam int ADDR_W  = $clog2(PAGES * COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              invalidate_i,
    input  logic [LINE_W-1:0] start_line_i,
    input  logic              inverse_i,
    input  logic              all_on_i,
    output logic [ADDR_W-1:0] ram_addr_o,
    input  logic [BYTE_W-1:0] ram_rdata_i,
    input  logic              pix_ready_i,
    output logic              pix_valid_o,
    output logic              pix_o,
    output logic              frame_start_o,
    output logic              line_end_o,
    output logic              redraw_pending_o
);

    localparam int X_W = $clog2(VIS_W);
    localparam int Y_W = $clog2(VIS_H);

    logic              take, frame_done, fvalid, inv, allon, first, lend, last;
    logic [BIT_W-1:0]  bitsel;
    logic [X_W-1:0]    nx;
    logic [Y_W-1:0]    ny;
    logic [LINE_W-1:0] nsl;

    oled_scan_seq #(
        .VIS_W (VIS_W), .VIS_H (VIS_H), .LINE_W (LINE_W), .X_W (X_W), .Y_W (Y_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .invalidate_i (invalidate_i),
        .start_line_i (start_line_i),
        .inverse_i    (inverse_i),
        .all_on_i     (all_on_i),
        .take_i       (take),
        .frame_done_i (frame_done),
        .fvalid_o     (fvalid),
        .bit_o        (bitsel),
        .inv_o        (inv),
        .allon_o      (allon),
        .first_o      (first),
        .lend_o       (lend),
        .last_o       (last),
        .nx_o         (nx),
        .ny_o         (ny),
        .nsl_o        (nsl),
        .pending_o    (redraw_pending_o)
    );

    oled_scan_addr #(
        .COLS (COLS), .COL_OFS (COL_OFS), .LINE_W (LINE_W),
        .ADDR_W (ADDR_W), .X_W (X_W), .Y_W (Y_W)
    ) u_addr (
        .x_i    (nx),
        .y_i    (ny),
        .sl_i   (nsl),
        .addr_o (ram_addr_o)
    );

    oled_scan_out u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .fvalid_i      (fvalid),
        .rdata_i       (ram_rdata_i),
        .bit_i         (bitsel),
        .inv_i         (inv),
        .allon_i       (allon),
        .first_i       (first),
        .lend_i        (lend),
        .last_i        (last),
        .pix_ready_i   (pix_ready_i),
        .take_o        (take),
        .pix_valid_o   (pix_valid_o),
        .pix_o         (pix_o),
        .frame_start_o (frame_start_o),
        .line_end_o    (line_end_o),
        .frame_done_o  (frame_done)
    );

    // R4
    addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(ram_addr_o) % COLS) >= COL_OFS) &&
        ((int'(ram_addr_o) % COLS) < COL_OFS + VIS_W) &&
        (int'(ram_addr_o) < PAGES * COLS));

endmodule

// File: tb/oled_scanout_test.sv
module oled_scanout_test;

    localparam int COLS  = 132;
    localparam int MEMSZ = 8 * COLS;
    localparam int NPIX  = 96 * 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        invalidate_i;
    logic [5:0]  start_line_i;
    logic        inverse_i;
    logic        all_on_i;
    logic [10:0] ram_addr_o;
    logic [7:0]  ram_rdata_i;
    logic        pix_ready_i;
    logic        pix_valid_o;
    logic        pix_o;
    logic        frame_start_o;
    logic        line_end_o;
    logic        redraw_pending_o;

    logic [7:0]  mem [0:MEMSZ-1];
    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    always @(posedge clk) ram_rdata_i <= mem[ram_addr_o];

    oled_scanout uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .invalidate_i     (invalidate_i),
        .start_line_i     (start_line_i),
        .inverse_i        (inverse_i),
        .all_on_i         (all_on_i),
        .ram_addr_o       (ram_addr_o),
        .ram_rdata_i      (ram_rdata_i),
        .pix_ready_i      (pix_ready_i),
        .pix_valid_o      (pix_valid_o),
        .pix_o            (pix_o),
        .frame_start_o    (frame_start_o),
        .line_end_o       (line_end_o),
        .redraw_pending_o (redraw_pending_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit exp_pix(int x, int y, int sl, bit inv, bit on);
        int line;
        logic [7:0] b;
        line = (y + sl) % 64;
        b    = mem[(line / 8) * COLS + 36 + x];
        return on ? 1'b1 : (b[line % 8] ^ inv);
    endfunction

    task automatic idle_check(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            chk(!pix_valid_o, tag, "pixel while idle", pix_valid_o, 0);
            chk(!redraw_pending_o, tag, "pending while idle", redraw_pending_o, 0);
            @(negedge clk);
        end
    endtask

    task automatic run_frame(input int sl, input bit inv, input bit on, input bit rnd,
                             input bit pulse, input bit mid_inval, input bit mid_flip,
                             input bit collide, input string tag);
        int idx = 0;
        int guard = 0;
        bit pv = 0, pr = 0, pp = 0, pfs = 0, ple = 0;
        @(negedge clk);
        start_line_i = 6'(sl);
        inverse_i    = inv;
        all_on_i     = on;
        invalidate_i = pulse;
        @(negedge clk);
        invalidate_i = 0;
        // R7: request raises the pending flag
        chk(redraw_pending_o, "R7", "pending after request", redraw_pending_o, 1);
        while (idx < NPIX && guard < 20000) begin
            bit rdy;
            guard++;
            rdy = rnd ? ($urandom_range(0, 3) != 0) : 1'b1;
            invalidate_i = 0;
            if (pv && !pr) begin
                // R9
                chk(pix_valid_o && pix_o == pp && frame_start_o == pfs && line_end_o == ple,
                    "R9", "stalled output changed", {pix_valid_o, pix_o}, {1'b1, pp});
            end
            if (mid_inval && idx == 500) invalidate_i = 1;
            if (mid_flip && idx == 700) begin
                start_line_i = ~6'(sl);
                inverse_i    = ~inv;
                all_on_i     = ~on;
            end
            if (collide && idx == NPIX - 1 && pix_valid_o) begin
                rdy = 1;
                invalidate_i = 1;
            end
            pix_ready_i = rdy;
            if (pix_valid_o && rdy) begin
                int x, y;
                bit e;
                x = idx % 96;
                y = idx / 96;
                e = exp_pix(x, y, sl, inv, on);
                chk(pix_o == e, tag, $sformatf("pixel x=%0d y=%0d", x, y), pix_o, e);
                // R2
                chk(frame_start_o == (idx == 0) && line_end_o == (x == 95), "R2",
                    $sformatf("markers at pixel %0d", idx), {frame_start_o, line_end_o},
                    {(idx == 0), (x == 95)});
                idx++;
            end
            pv = pix_valid_o; pr = rdy; pp = pix_o; pfs = frame_start_o; ple = line_end_o;
            @(negedge clk);
        end
        invalidate_i = 0;
        pix_ready_i  = 1;
        // R2
        chk(idx == NPIX, "R2", "pixels in frame", idx, NPIX);
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < MEMSZ; i++) mem[i] = 8'($urandom);
        rst_n = 0; invalidate_i = 0; start_line_i = 0; inverse_i = 0;
        all_on_i = 0; pix_ready_i = 1;
        repeat (3) @(negedge clk);
        // R1
        chk(!pix_valid_o, "R1", "valid in reset", pix_valid_o, 0);
        chk(!redraw_pending_o, "R1", "pending in reset", redraw_pending_o, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!pix_valid_o && !redraw_pending_o, "R1", "state after reset",
            {pix_valid_o, redraw_pending_o}, 0);
        // R7: nothing without a request
        idle_check(40, "R7");

        // R3 R4: plain mapping, no scroll
        run_frame(0, 0, 0, 0, 1, 0, 0, 0, "R3");
        idle_check(20, "R8");
        // R5 with wrap of the line index (R3)
        run_frame(60, 1, 0, 0, 1, 0, 0, 0, "R5");
        idle_check(20, "R8");
        // R6 force-lit beats invert
        run_frame(5, 1, 1, 1, 1, 0, 0, 0, "R6");
        idle_check(20, "R8");
        // R10 config changed mid-frame; R8 mid-frame request absorbed
        run_frame(int'($urandom_range(0, 63)), 0, 0, 1, 1, 1, 1, 0, "R10");
        idle_check(30, "R8");
        // R8 request in the final-accept cycle wins
        run_frame(17, 1, 0, 1, 1, 0, 0, 1, "R4");
        chk(redraw_pending_o, "R8", "pending after colliding request", redraw_pending_o, 1);
        run_frame(17, 1, 0, 1, 0, 0, 0, 0, "R8");
        idle_check(30, "R8");
        // random configurations under back-pressure
        for (int f = 0; f < 3; f++) begin
            for (int i = 0; i < MEMSZ; i++) mem[i] = 8'($urandom);
            run_frame(int'($urandom_range(0, 63)), 1'($urandom), 1'b0, 1, 1, 0, 0, 0, "R3");
            idle_check(10, "R8");
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R2 watchdog expired: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule